// File: doc/BRIEF.md
# Two-Slot Integer Register Bank

This block is the architectural integer register storage for a core that issues two instructions per cycle. It holds 32 registers of 32 bits. Each issue slot owns one write port and two source-operand read ports, so up to two results are retired and four operands are fetched in every cycle. A fifth read port, addressed separately, lets board-level switches select any register for display.

Writes are captured on the rising clock edge. All five read ports are combinational. Each read port also sees, in the same cycle, any value that is being written to the register it addresses. Register zero is a constant zero and cannot be written. When both slots write the same register in one cycle, the slot 1 value is kept, because slot 1 is the younger instruction. This rule applies to both the stored value and the bypassed value. An asynchronous active-low reset clears every register. Forwarding from later pipeline stages is handled outside this block.

Top module: `dual_issue_regbank`

## Requirements
- R1: While reset is low, and after it is released, every register reads as zero on every read port until it is written.
- R2: When the slot 0 write enable is high at a rising edge with a nonzero address, that register holds the slot 0 data from the next cycle onward.
- R3: When the slot 1 write enable is high at a rising edge with a nonzero address, that register holds the slot 1 data from the next cycle onward.
- R4: Both write ports can target two different registers in the same cycle, and both registers are updated at the same edge.
- R5: When both write ports target the same nonzero register in one cycle, the register afterwards holds the slot 1 data.
- R6: A read port whose address matches an enabled write in the current cycle returns that write's data in the same cycle. This holds on all four operand read ports.
- R7: When both enabled writes target the register that a port reads in the current cycle, that port returns the slot 1 data.
- R8: Address 0 always reads as 0. This includes the cycle in which a write targets address 0 and every cycle afterwards, so writes to address 0 are discarded.
- R9: The debug port returns the addressed register with the same same-cycle write bypass and the same zero rule as the operand ports.
- R10: A write port whose enable is low changes no register and supplies no bypass data, whatever its address and data inputs carry.
- R11: A register that is not written keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears all registers |
| wr0_en | input | 1 | Slot 0 write enable |
| wr0_addr | input | 5 | Slot 0 destination register |
| wr0_data | input | 32 | Slot 0 write value |
| wr1_en | input | 1 | Slot 1 write enable (wins on a same-register collision) |
| wr1_addr | input | 5 | Slot 1 destination register |
| wr1_data | input | 32 | Slot 1 write value |
| s0a_addr | input | 5 | Slot 0 first source register |
| s0a_data | output | 32 | Slot 0 first operand |
| s0b_addr | input | 5 | Slot 0 second source register |
| s0b_data | output | 32 | Slot 0 second operand |
| s1a_addr | input | 5 | Slot 1 first source register |
| s1a_data | output | 32 | Slot 1 first operand |
| s1b_addr | input | 5 | Slot 1 second source register |
| s1b_data | output | 32 | Slot 1 second operand |
| dbg_addr | input | 5 | Inspection register select |
| dbg_data | output | 32 | Inspection read value |

## Verification
Every read result belongs to the cycle in which its address and the write inputs are applied. Bypassed data is therefore due with zero latency, and a stored value is due in the first cycle after the write edge. The bench changes inputs on the falling edge and compares all five read ports 1 ns later, still before the next rising edge. It then updates its reference array at the rising edge. As a result, each comparison sees the current-cycle bypass against the stored state from earlier edges, and a stored write is checked in the cycle that follows it.

// File: rtl/regbank_pkg.sv
`timescale 1ns/1ps
package regbank_pkg;
  // Number of write ports; higher index is younger in program order.
  localparam int unsigned WR_PORTS = 2;

  // Read port indices inside the block.
  localparam int unsigned RP_S0A   = 0;
  localparam int unsigned RP_S0B   = 1;
  localparam int unsigned RP_S1A   = 2;
  localparam int unsigned RP_S1B   = 3;
  localparam int unsigned RP_DBG   = 4;
  localparam int unsigned RP_COUNT = 5;
endpackage

// File: rtl/regbank_wsel.sv
`timescale 1ns/1ps
// Per-entry write selection: decides whether this entry loads and from
// which port. A later port overrides an earlier one.
module regbank_wsel #(
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WR_PORTS  = 2,
  parameter int unsigned INDEX     = 1,
  localparam int unsigned ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic [WR_PORTS-1:0]             wr_en,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0] wr_addr,
  input  logic [WR_PORTS-1:0][DATA_W-1:0] wr_data,
  output logic                            load,
  output logic [DATA_W-1:0]               load_data
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(INDEX);

  always_comb begin
    load      = 1'b0;
    load_data = '0;
    for (int p = 0; p < int'(WR_PORTS); p++) begin
      if (wr_en[p] && (wr_addr[p] == MY_ADDR)) begin
        load      = 1'b1;
        load_data = wr_data[p];
      end
    end
  end
endmodule

// File: rtl/regbank_array.sv
`timescale 1ns/1ps
// Storage for entries 1..REG_COUNT-1; entry 0 is a constant zero.
module regbank_array #(
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WR_PORTS  = 2,
  localparam int unsigned ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [WR_PORTS-1:0]                wr_en,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0]    wr_addr,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]    wr_data,
  output logic [REG_COUNT-1:0][DATA_W-1:0]   entries
);
  assign entries[0] = '0;

  for (genvar e = 1; e < REG_COUNT; e++) begin : g_entry
    logic              load;
    logic [DATA_W-1:0] load_data;
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] nxt_d;

    regbank_wsel #(
      .REG_COUNT (REG_COUNT),
      .DATA_W    (DATA_W),
      .WR_PORTS  (WR_PORTS),
      .INDEX     (e)
    ) u_wsel (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .load      (load),
      .load_data (load_data)
    );

    // Next-state process
    always_comb begin
      nxt_d = cur_q;
      if (load) nxt_d = load_data;
    end

    // Register process with explicit clock enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_q <= '0;
      end else if (load) begin
        cur_q <= nxt_d;
      end
    end

    assign entries[e] = cur_q;
  end
endmodule

// File: rtl/regbank_rport.sv
`timescale 1ns/1ps
// One combinational read port with same-cycle write bypass.
// The youngest matching write wins; address 0 is forced to zero last.
module regbank_rport #(
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WR_PORTS  = 2,
  localparam int unsigned ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic [REG_COUNT-1:0][DATA_W-1:0] entries,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [WR_PORTS-1:0]              wr_en,
  input  logic [WR_PORTS-1:0][ADDR_W-1:0]  wr_addr,
  input  logic [WR_PORTS-1:0][DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]                rd_data
);
  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = entries[rd_addr];
    for (int p = 0; p < int'(WR_PORTS); p++) begin
      if (wr_en[p] && (wr_addr[p] == rd_addr)) picked = wr_data[p];
    end
  end

  assign rd_data = (rd_addr == '0) ? '0 : picked;
endmodule

// File: rtl/dual_issue_regbank.sv
`timescale 1ns/1ps
module dual_issue_regbank #(
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  input  logic [ADDR_W-1:0] s0a_addr,
  output logic [DATA_W-1:0] s0a_data,
  input  logic [ADDR_W-1:0] s0b_addr,
  output logic [DATA_W-1:0] s0b_data,
  input  logic [ADDR_W-1:0] s1a_addr,
  output logic [DATA_W-1:0] s1a_data,
  input  logic [ADDR_W-1:0] s1b_addr,
  output logic [DATA_W-1:0] s1b_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  import regbank_pkg::*;

  logic [WR_PORTS-1:0]                  wen;
  logic [WR_PORTS-1:0][ADDR_W-1:0]      wadr;
  logic [WR_PORTS-1:0][DATA_W-1:0]      wdat;
  logic [RP_COUNT-1:0][ADDR_W-1:0]      radr;
  logic [RP_COUNT-1:0][DATA_W-1:0]      rdat;
  logic [REG_COUNT-1:0][DATA_W-1:0]     entries;

  // Slot 0 at index 0, slot 1 at index 1 (index order = priority order)
  assign wen  = {wr1_en,   wr0_en};
  assign wadr = {wr1_addr, wr0_addr};
  assign wdat = {wr1_data, wr0_data};

  assign radr[RP_S0A] = s0a_addr;
  assign radr[RP_S0B] = s0b_addr;
  assign radr[RP_S1A] = s1a_addr;
  assign radr[RP_S1B] = s1b_addr;
  assign radr[RP_DBG] = dbg_addr;

  regbank_array #(
    .REG_COUNT (REG_COUNT),
    .DATA_W    (DATA_W),
    .WR_PORTS  (WR_PORTS)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wen),
    .wr_addr (wadr),
    .wr_data (wdat),
    .entries (entries)
  );

  for (genvar r = 0; r < RP_COUNT; r++) begin : g_rport
    regbank_rport #(
      .REG_COUNT (REG_COUNT),
      .DATA_W    (DATA_W),
      .WR_PORTS  (WR_PORTS)
    ) u_rport (
      .entries (entries),
      .rd_addr (radr[r]),
      .wr_en   (wen),
      .wr_addr (wadr),
      .wr_data (wdat),
      .rd_data (rdat[r])
    );
  end

  assign s0a_data = rdat[RP_S0A];
  assign s0b_data = rdat[RP_S0B];
  assign s1a_data = rdat[RP_S1A];
  assign s1b_data = rdat[RP_S1B];
  assign dbg_data = rdat[RP_DBG];
endmodule

// File: rtl/regbank_chk.sv
`timescale 1ns/1ps
module regbank_chk #(
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned ADDR_W   = $clog2(REG_COUNT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr0_en,
  input logic [ADDR_W-1:0] wr0_addr,
  input logic [DATA_W-1:0] wr0_data,
  input logic              wr1_en,
  input logic [ADDR_W-1:0] wr1_addr,
  input logic [DATA_W-1:0] wr1_data,
  input logic [ADDR_W-1:0] s0a_addr,
  input logic [DATA_W-1:0] s0a_data,
  input logic [ADDR_W-1:0] s0b_addr,
  input logic [DATA_W-1:0] s0b_data,
  input logic [ADDR_W-1:0] s1a_addr,
  input logic [DATA_W-1:0] s1a_data,
  input logic [ADDR_W-1:0] s1b_addr,
  input logic [DATA_W-1:0] s1b_data,
  input logic [ADDR_W-1:0] dbg_addr,
  input logic [DATA_W-1:0] dbg_data
);
  // R8
  zero_s0a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s0a_addr == '0) |-> (s0a_data == '0));

  // R9
  zero_dbg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == '0) |-> (dbg_data == '0));

  // R6
  bypass_s0b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && (wr0_addr != '0) && !(wr1_en && (wr1_addr == wr0_addr)) &&
     (s0b_addr == wr0_addr)) |-> (s0b_data == wr0_data));

  // R6
  bypass_s1b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1_en && (wr1_addr != '0) && (s1b_addr == wr1_addr)) |-> (s1b_data == wr1_data));

  // R7
  collide_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && wr1_en && (wr0_addr == wr1_addr) && (wr1_addr != '0) &&
     (s1a_addr == wr1_addr)) |-> (s1a_data == wr1_data));

  // R2
  store_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && (wr0_addr != '0) && !(wr1_en && (wr1_addr == wr0_addr))) ##1
    ((dbg_addr == $past(wr0_addr)) && !(wr0_en && (wr0_addr == dbg_addr)) &&
     !(wr1_en && (wr1_addr == dbg_addr)))
    |-> (dbg_data == $past(wr0_data)));

  // R5
  collide_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && wr1_en && (wr0_addr == wr1_addr) && (wr1_addr != '0)) ##1
    ((dbg_addr == $past(wr1_addr)) && !(wr0_en && (wr0_addr == dbg_addr)) &&
     !(wr1_en && (wr1_addr == dbg_addr)))
    |-> (dbg_data == $past(wr1_data)));

  // R11
  hold_s0a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(s0a_addr) &&
     !$past(wr0_en && (wr0_addr == s0a_addr)) && !$past(wr1_en && (wr1_addr == s0a_addr)) &&
     !(wr0_en && (wr0_addr == s0a_addr)) && !(wr1_en && (wr1_addr == s0a_addr)))
    |-> $stable(s0a_data));
endmodule

bind dual_issue_regbank regbank_chk #(
  .REG_COUNT (REG_COUNT),
  .DATA_W    (DATA_W)
) u_regbank_chk (.*);

// File: tb/test_dual_issue_regbank.sv
`timescale 1ns/1ps
module test_dual_issue_regbank;
  logic        clk;
  logic        rst_n;
  logic        wr0_en, wr1_en;
  logic [4:0]  wr0_addr, wr1_addr;
  logic [31:0] wr0_data, wr1_data;
  logic [4:0]  s0a_addr, s0b_addr, s1a_addr, s1b_addr, dbg_addr;
  logic [31:0] s0a_data, s0b_data, s1a_data, s1b_data, dbg_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [31:0] ref_q [32];
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  dual_issue_regbank i_dual_issue_regbank (
    .clk(clk), .rst_n(rst_n),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .s0a_addr(s0a_addr), .s0a_data(s0a_data),
    .s0b_addr(s0b_addr), .s0b_data(s0b_data),
    .s1a_addr(s1a_addr), .s1a_data(s1a_data),
    .s1b_addr(s1b_addr), .s1b_data(s1b_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural expectation: zero register, youngest same-cycle write, else stored
  function automatic logic [31:0] expect_rd(input logic [4:0] a);
    if (a == 5'd0) return 32'd0;
    if (wr1_en && wr1_addr == a) return wr1_data;
    if (wr0_en && wr0_addr == a) return wr0_data;
    return ref_q[a];
  endfunction

  task automatic check(input string tag, input string port,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs set; returns after next falling edge.
  task automatic cycle(input string tag);
    if (!rst_n) for (int r = 0; r < 32; r++) ref_q[r] = 32'd0;
    #1;
    check(tag, "s0a", s0a_data, expect_rd(s0a_addr));
    check(tag, "s0b", s0b_data, expect_rd(s0b_addr));
    check(tag, "s1a", s1a_data, expect_rd(s1a_addr));
    check(tag, "s1b", s1b_data, expect_rd(s1b_addr));
    check(tag, "dbg", dbg_data, expect_rd(dbg_addr));
    @(posedge clk);
    if (rst_n) begin
      if (wr0_en && wr0_addr != 5'd0) ref_q[wr0_addr] = wr0_data;
      if (wr1_en && wr1_addr != 5'd0) ref_q[wr1_addr] = wr1_data;
    end
    @(negedge clk);
  endtask

  task automatic set_rd(input int a, input int b, input int c, input int d, input int g);
    s0a_addr = 5'(a); s0b_addr = 5'(b); s1a_addr = 5'(c); s1b_addr = 5'(d); dbg_addr = 5'(g);
  endtask

  task automatic set_w0(input bit en, input int a, input logic [31:0] d);
    wr0_en = en; wr0_addr = 5'(a); wr0_data = d;
  endtask

  task automatic set_w1(input bit en, input int a, input logic [31:0] d);
    wr1_en = en; wr1_addr = 5'(a); wr1_data = d;
  endtask

  task automatic idle();
    set_w0(0, 0, 32'd0);
    set_w1(0, 0, 32'd0);
  endtask

  function automatic logic [31:0] step_lfsr(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    for (int r = 0; r < 32; r++) ref_q[r] = 32'd0;
    rst_n = 1'b0;
    idle();
    set_rd(1, 2, 3, 4, 5);
    @(negedge clk);
    // R1: reads during reset
    cycle("R1");
    rst_n = 1'b1;
    // R1: every register zero after release
    for (int r = 0; r < 32; r++) begin
      set_rd(r, (r + 1) % 32, (r + 2) % 32, (r + 3) % 32, r);
      cycle("R1");
    end

    // R2: slot 0 writes then readback
    for (int k = 1; k <= 6; k++) begin
      set_w0(1, k, 32'hA000_0000 + k);
      set_rd(20, 21, 22, 23, 24);
      cycle("R2");
    end
    idle();
    set_rd(1, 2, 3, 4, 5); cycle("R2");
    set_rd(6, 6, 1, 2, 6); cycle("R2");

    // R3: slot 1 writes then readback
    for (int k = 10; k <= 15; k++) begin
      set_w1(1, k, 32'hB100_0000 + k);
      set_rd(1, 2, 3, 4, 5);
      cycle("R3");
    end
    idle();
    set_rd(10, 11, 12, 13, 14); cycle("R3");
    set_rd(15, 15, 15, 15, 15); cycle("R3");

    // R4: two different registers in one cycle
    set_w0(1, 20, 32'hC0DE_0020);
    set_w1(1, 21, 32'hC0DE_0021);
    set_rd(1, 10, 2, 11, 3);
    cycle("R4");
    idle();
    set_rd(20, 21, 21, 20, 21); cycle("R4");

    // R5: same register from both slots, slot 1 must be kept
    set_w0(1, 7, 32'h0000_0A0A);
    set_w1(1, 7, 32'h0000_0B0B);
    set_rd(1, 2, 3, 4, 5);
    cycle("R5");
    idle();
    set_rd(7, 7, 7, 7, 7); cycle("R5");

    // R6: bypass on all four operand ports, from each slot
    set_w0(1, 3, 32'h3333_0000);
    set_rd(3, 3, 3, 3, 1);
    cycle("R6");
    idle();
    set_w1(1, 4, 32'h4444_1111);
    set_rd(4, 4, 4, 4, 2);
    cycle("R6");
    idle();
    set_w0(1, 8, 32'h8888_0008);
    set_w1(1, 9, 32'h9999_0009);
    set_rd(8, 9, 9, 8, 3);
    cycle("R6");
    idle();

    // R7: collision bypass, slot 1 data on every port
    set_w0(1, 9, 32'hDEAD_0000);
    set_w1(1, 9, 32'hBEEF_1111);
    set_rd(9, 9, 9, 9, 9);
    cycle("R7");
    idle();
    set_rd(9, 9, 9, 9, 9); cycle("R7");

    // R8: writes to register zero are ignored, no bypass
    set_w0(1, 0, 32'hFFFF_FFFF);
    set_w1(1, 0, 32'h1234_5678);
    set_rd(0, 0, 0, 0, 0);
    cycle("R8");
    set_w0(1, 0, 32'h5555_5555);
    set_w1(0, 0, 32'd0);
    cycle("R8");
    idle();
    cycle("R8");

    // R9: debug port bypass and storage
    set_w0(1, 30, 32'h0D0D_3030);
    set_rd(1, 2, 3, 4, 30);
    cycle("R9");
    idle();
    set_w1(1, 31, 32'h0D0D_3131);
    set_rd(30, 2, 3, 4, 31);
    cycle("R9");
    idle();
    set_rd(1, 2, 3, 4, 31); cycle("R9");

    // R10: disabled ports carry junk but change nothing
    set_w0(0, 5, 32'hBAD0_BAD0);
    set_w1(0, 6, 32'hBAD1_BAD1);
    set_rd(5, 6, 5, 6, 5);
    cycle("R10");
    cycle("R10");
    idle();
    set_rd(5, 6, 5, 6, 6); cycle("R10");

    // R11: hold over idle cycles
    for (int k = 0; k < 5; k++) begin
      set_rd(1 + k, 10 + k, 20, 21, 7);
      cycle("R11");
    end

    // R1: reset in mid-run clears stored values
    rst_n = 1'b0;
    set_rd(1, 7, 20, 31, 9);
    cycle("R1");
    rst_n = 1'b1;
    for (int r = 1; r < 32; r += 4) begin
      set_rd(r, r + 1, r + 2, r + 3, r);
      cycle("R1");
    end

    // R4: mixed traffic with frequent collisions and register zero hits
    for (int k = 0; k < 300; k++) begin
      lfsr = step_lfsr(lfsr);
      set_w0(lfsr[0], int'(lfsr[5:3]), lfsr ^ 32'h0F0F_0000);
      lfsr = step_lfsr(lfsr);
      set_w1(lfsr[1], int'(lfsr[6:4]), lfsr ^ 32'h00F0_F0F0);
      lfsr = step_lfsr(lfsr);
      set_rd(int'(lfsr[2:0]), int'(lfsr[5:3]), int'(lfsr[8:6]),
             int'(lfsr[11:9]), int'(lfsr[16:12]));
      cycle("R4");
    end
    idle();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #80000;
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule